// File: doc/BRIEF.md
# Interleaved Four-Bank Cache Block Fetch

This block serves a cache refill port from a memory split into independent banks, with consecutive words in consecutive banks. The word address modulo the bank count picks the bank, so bank 0 holds words 0, 4, 8, … and bank 1 holds words 1, 5, 9, …. A cache block is one word from each bank. Every bank therefore stores a block's word at the same row, and that row equals the block address.

When a block address is accepted, the block sends that row to all banks in the same cycle. It then waits until every bank has delivered its word and streams the words out in bank order, one per cycle, on a one-word bus, with a flag on the final word. The bank accesses overlap, so the miss penalty is one address cycle, one access time, and four transfer cycles. With 10-cycle banks, the last word appears 15 cycles after acceptance. A single bank doing four serial accesses would take 48 cycles.

Bank access time is not fixed inside the block. Each bank reports its own data-valid strobe and its own busy flag, and the busy flag covers the full bank cycle time. A new request is refused until every bank is idle and the previous block has left the output.

Top module: `ilv_block_fetch`

## Requirements
- R1: After reset, `req_ready` is 1, `out_valid` is 0 and `bank_req` is all zeros.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. In the next cycle only, every bit of `bank_req` is 1 and `bank_row` carries the accepted block address.
- R3: `req_ready` is 0 in each of these cases: any `bank_busy` bit is 1, a fetch is between acceptance and the arrival of its last bank word, or a block is still on the output. A `req_valid` held high is accepted in the first cycle in which `req_ready` returns to 1.
- R4: The word of block address A at word offset i (word address 4·A+i) is taken from bank i, slice i of `bank_rdata` (bits 32·i+31 down to 32·i), in the cycle where `bank_dvalid[i]` is 1 during that fetch.
- R5: A block leaves as four consecutive `out_valid` cycles carrying the bank 0, 1, 2, 3 words in that order. `out_last` is 1 only with the fourth word.
- R6: If the banks raise data-valid L cycles after the cycle in which `bank_req` was high, the first word appears L+2 cycles after the accept cycle. With L = 10, the last word appears in cycle 15, counting the accept cycle as cycle 0.
- R7: If banks answer at different times, streaming starts in the cycle after the latest bank's data-valid. The order stays bank 0 to 3.
- R8: A `bank_dvalid` pulse while no fetch is waiting for data has no effect. No output word appears and the next block carries only its own bank data.
- R9: A bank whose busy flag stays high after it has delivered data keeps `req_ready` at 0 until that flag falls, even after the block has finished streaming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Block request present |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_blk_addr | input | ROW_W (10) | Block address, which is the bank row |
| bank_req | output | NB (4) | One-cycle access start, one bit per bank |
| bank_row | output | ROW_W (10) | Row sent to all banks |
| bank_busy | input | NB (4) | Bank still within its cycle time |
| bank_dvalid | input | NB (4) | Bank read data present |
| bank_rdata | input | NB*WORD_W (128) | Read data, bank i in slice i |
| out_valid | output | 1 | Output word present |
| out_last | output | 1 | Final word of the block |
| out_data | output | WORD_W (32) | Output word |

## Verification
The hardest cases to reach from the ports are those where the three conditions that hold `req_ready` low stop overlapping. One case is a bank whose busy flag lasts well past both its data and the end of streaming. Another is a set of banks whose data-valid strobes arrive in an order opposite to the output order. The bench's bank models take a separate access time and busy length for each bank, so it can run skewed latencies, a long tail on a single bank, one-cycle banks, and a stray data-valid pulse while idle. A request is held valid across a busy window to show that it is taken in the first free cycle.

// File: rtl/ilv_fetch_pkg.sv
package ilv_fetch_pkg;

    localparam int unsigned DEF_BANKS  = 4;
    localparam int unsigned DEF_WORD_W = 32;
    localparam int unsigned DEF_ROW_W  = 10;

    typedef enum logic [1:0] {
        FS_IDLE  = 2'd0,
        FS_ISSUE = 2'd1,
        FS_WAIT  = 2'd2
    } fetch_st_e;

    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ilv_issue_ctrl.sv
module ilv_issue_ctrl
    import ilv_fetch_pkg::*;
#(
    parameter int unsigned NB    = DEF_BANKS,
    parameter int unsigned ROW_W = DEF_ROW_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [ROW_W-1:0] req_row,
    input  logic [NB-1:0]    bank_busy,
    input  logic             stream_busy,
    input  logic             all_done,
    output logic             accept,
    output logic             waiting,
    output logic [NB-1:0]    bank_req,
    output logic [ROW_W-1:0] bank_row
);

    fetch_st_e        st_q;
    logic [ROW_W-1:0] row_q;

    assign req_ready = (st_q == FS_IDLE) && !(|bank_busy) && !stream_busy;
    assign accept    = req_valid && req_ready;
    assign waiting   = (st_q == FS_WAIT);
    assign bank_req  = {NB{st_q == FS_ISSUE}};
    assign bank_row  = row_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= FS_IDLE;
            row_q <= '0;
        end else begin
            case (st_q)
                FS_IDLE: begin
                    if (accept) begin
                        st_q  <= FS_ISSUE;
                        row_q <= req_row;
                    end
                end
                FS_ISSUE: st_q <= FS_WAIT;
                FS_WAIT:  if (all_done) st_q <= FS_IDLE;
                default:  st_q <= FS_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ilv_word_collect.sv
module ilv_word_collect
    import ilv_fetch_pkg::*;
#(
    parameter int unsigned NB     = DEF_BANKS,
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clear,
    input  logic                 enable,
    input  logic [NB-1:0]        dvalid,
    input  logic [NB*WORD_W-1:0] rdata,
    output logic [NB*WORD_W-1:0] words,
    output logic                 all_done
);

    logic [NB-1:0] got;

    for (genvar b = 0; b < NB; b++) begin : g_bank
        logic              got_b;
        logic [WORD_W-1:0] word_b;

        always_ff @(posedge clk) begin
            if (rst) begin
                got_b  <= 1'b0;
                word_b <= '0;
            end else if (clear) begin
                got_b  <= 1'b0;
            end else if (enable && dvalid[b] && !got_b) begin
                got_b  <= 1'b1;
                word_b <= rdata[b*WORD_W +: WORD_W];
            end
        end

        assign got[b]                    = got_b;
        assign words[b*WORD_W +: WORD_W] = word_b;
    end

    assign all_done = enable && (&(got | dvalid));

endmodule

// File: rtl/ilv_beat_serializer.sv
module ilv_beat_serializer
    import ilv_fetch_pkg::*;
#(
    parameter int unsigned NB     = DEF_BANKS,
    parameter int unsigned WORD_W = DEF_WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [NB*WORD_W-1:0] words,
    output logic                 busy,
    output logic                 out_valid,
    output logic                 out_last,
    output logic [WORD_W-1:0]    out_data
);

    localparam int unsigned       IDX_W    = idx_width(NB);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NB - 1);

    logic              active_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] w_arr [NB];

    for (genvar b = 0; b < NB; b++) begin : g_unpack
        assign w_arr[b] = words[b*WORD_W +: WORD_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            idx_q    <= '0;
        end else if (start) begin
            active_q <= 1'b1;
            idx_q    <= '0;
        end else if (active_q) begin
            if (idx_q == LAST_IDX) begin
                active_q <= 1'b0;
                idx_q    <= '0;
            end else begin
                idx_q <= idx_q + 1'b1;
            end
        end
    end

    assign busy      = active_q;
    assign out_valid = active_q;
    assign out_last  = active_q && (idx_q == LAST_IDX);
    assign out_data  = active_q ? w_arr[idx_q] : '0;

endmodule

// File: rtl/ilv_block_fetch.sv
module ilv_block_fetch
    import ilv_fetch_pkg::*;
#(
    parameter int unsigned NB     = DEF_BANKS,
    parameter int unsigned WORD_W = DEF_WORD_W,
    parameter int unsigned ROW_W  = DEF_ROW_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [ROW_W-1:0]     req_blk_addr,
    output logic [NB-1:0]        bank_req,
    output logic [ROW_W-1:0]     bank_row,
    input  logic [NB-1:0]        bank_busy,
    input  logic [NB-1:0]        bank_dvalid,
    input  logic [NB*WORD_W-1:0] bank_rdata,
    output logic                 out_valid,
    output logic                 out_last,
    output logic [WORD_W-1:0]    out_data
);

    logic                 accept;
    logic                 waiting;
    logic                 all_done;
    logic                 stream_busy;
    logic [NB*WORD_W-1:0] words;

    ilv_issue_ctrl #(.NB(NB), .ROW_W(ROW_W)) u_issue (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_row    (req_blk_addr),
        .bank_busy  (bank_busy),
        .stream_busy(stream_busy),
        .all_done   (all_done),
        .accept     (accept),
        .waiting    (waiting),
        .bank_req   (bank_req),
        .bank_row   (bank_row)
    );

    ilv_word_collect #(.NB(NB), .WORD_W(WORD_W)) u_collect (
        .clk     (clk),
        .rst     (rst),
        .clear   (accept),
        .enable  (waiting),
        .dvalid  (bank_dvalid),
        .rdata   (bank_rdata),
        .words   (words),
        .all_done(all_done)
    );

    ilv_beat_serializer #(.NB(NB), .WORD_W(WORD_W)) u_ser (
        .clk      (clk),
        .rst      (rst),
        .start    (all_done),
        .words    (words),
        .busy     (stream_busy),
        .out_valid(out_valid),
        .out_last (out_last),
        .out_data (out_data)
    );

endmodule

// File: rtl/ilv_block_fetch_chk.sv
module ilv_block_fetch_chk #(
    parameter int unsigned NB    = 4,
    parameter int unsigned ROW_W = 10
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic             req_ready,
    input logic [ROW_W-1:0] req_blk_addr,
    input logic [NB-1:0]    bank_req,
    input logic [ROW_W-1:0] bank_row,
    input logic [NB-1:0]    bank_busy,
    input logic             out_valid,
    input logic             out_last
);

    assert_issue_after_accept_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (&bank_req));

    assert_issue_single_R2: assert property (@(posedge clk) disable iff (rst)
        (|bank_req) |=> (bank_req == '0));

    assert_row_matches_R2: assert property (@(posedge clk) disable iff (rst)
        (|bank_req) |-> (bank_row == $past(req_blk_addr)));

    assert_no_ready_busy_R3: assert property (@(posedge clk) disable iff (rst)
        (|bank_busy) |-> !req_ready);

    assert_no_ready_stream_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !req_ready);

    assert_last_in_stream_R5: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    assert_stream_contig_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

endmodule

bind ilv_block_fetch ilv_block_fetch_chk #(.NB(NB), .ROW_W(ROW_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_blk_addr(req_blk_addr),
    .bank_req    (bank_req),
    .bank_row    (bank_row),
    .bank_busy   (bank_busy),
    .out_valid   (out_valid),
    .out_last    (out_last)
);

// File: tb/ilv_block_fetch_tb.sv
module ilv_block_fetch_tb;

    localparam int NB = 4;
    localparam int WW = 32;
    localparam int RW = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [RW-1:0]    req_blk_addr = '0;
    logic [NB-1:0]    bank_req;
    logic [RW-1:0]    bank_row;
    logic [NB-1:0]    bank_busy = '0;
    logic [NB-1:0]    bank_dvalid = '0;
    logic [NB*WW-1:0] bank_rdata = '0;
    logic             out_valid;
    logic             out_last;
    logic [WW-1:0]    out_data;

    always #10 clk = ~clk;

    ilv_block_fetch #(.NB(NB), .WORD_W(WW), .ROW_W(RW)) u_dut (.*);

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int phase = 0;

    int lat_set [NB];
    int occ_set [NB];
    int req_at  [NB];
    int lat_cur [NB];
    int occ_cur [NB];
    int row_at  [NB];
    int stray_cyc = -1;
    int stray_bank = 0;

    int pend [$];
    int ecyc [$];
    logic [WW-1:0] edat [$];
    bit  elast [$];
    int issue_cyc = -1;
    int exp_row = 0;
    int accept_cyc = 0;
    int ready_free = 0;

    function automatic logic [WW-1:0] wval(input int w);
        return 32'h3C00_0000 ^ (w * 32'h0001_0007);
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        cyc++;
        // drive inputs for this cycle
        req_valid = (pend.size() > 0);
        req_blk_addr = (pend.size() > 0) ? RW'(pend[0]) : '0;
        for (int b = 0; b < NB; b++) begin
            bank_busy[b]   = (req_at[b] >= 0) && (cyc > req_at[b]) && (cyc <= req_at[b] + occ_cur[b]);
            bank_dvalid[b] = (req_at[b] >= 0) && (cyc == req_at[b] + lat_cur[b]);
            bank_rdata[b*WW +: WW] = bank_dvalid[b] ? wval(row_at[b] * 4 + b) : 32'h0;
            if (cyc == stray_cyc && b == stray_bank) begin
                bank_dvalid[b] = 1'b1;
                bank_rdata[b*WW +: WW] = 32'hDEAD_0000 + b;
            end
        end
        #1;
        // R3 / R9: ready follows bank idle and stream completion
        chk(req_ready == (cyc >= ready_free), (phase == 5) ? "R9" : "R3", "req_ready",
            req_ready, (cyc >= ready_free));
        // R2: one-cycle broadcast with the accepted row
        chk(bank_req == ((cyc == issue_cyc) ? {NB{1'b1}} : '0), "R2", "bank_req",
            bank_req, (cyc == issue_cyc) ? 15 : 0);
        if (cyc == issue_cyc)
            chk(bank_row == RW'(exp_row), "R2", "bank_row", bank_row, exp_row);
        // R4 / R5 / R7 / R8: output stream order and data
        if (ecyc.size() > 0 && ecyc[0] == cyc) begin
            chk(out_valid == 1'b1, "R5", "out_valid", out_valid, 1);
            chk(out_data == edat[0], (phase == 4) ? "R7" : "R4", "out_data", out_data, edat[0]);
            chk(out_last == elast[0], "R5", "out_last", out_last, elast[0]);
            if (elast[0] && phase == 2)
                chk(cyc - accept_cyc == 15, "R6", "block latency", cyc - accept_cyc, 15);
            void'(ecyc.pop_front()); void'(edat.pop_front()); void'(elast.pop_front());
        end else begin
            chk(out_valid == 1'b0, (phase == 6) ? "R8" : "R5", "out_valid idle", out_valid, 0);
        end
        // reference model: acceptance
        if (req_valid && req_ready) begin
            int maxlat = 0;
            int maxocc = 0;
            int c0;
            for (int b = 0; b < NB; b++) begin
                if (lat_set[b] > maxlat) maxlat = lat_set[b];
                if (occ_set[b] > maxocc) maxocc = occ_set[b];
            end
            accept_cyc = cyc;
            issue_cyc  = cyc + 1;
            exp_row    = pend[0];
            c0 = cyc + maxlat + 2;
            for (int i = 0; i < NB; i++) begin
                ecyc.push_back(c0 + i);
                edat.push_back(wval(pend[0] * 4 + i));
                elast.push_back(i == NB - 1);
            end
            ready_free = (c0 + NB > cyc + 2 + maxocc) ? c0 + NB : cyc + 2 + maxocc;
            void'(pend.pop_front());
        end
        // bank models see the access start
        for (int b = 0; b < NB; b++) begin
            if (bank_req[b]) begin
                req_at[b]  = cyc;
                lat_cur[b] = lat_set[b];
                occ_cur[b] = occ_set[b];
                row_at[b]  = int'(bank_row);
            end
        end
    endtask

    task automatic drain();
        while (pend.size() > 0 || ecyc.size() > 0 || cyc < ready_free) step();
        step();
        step();
    endtask

    task automatic set_banks(input int l0, l1, l2, l3, o0, o1, o2, o3);
        lat_set = '{l0, l1, l2, l3};
        occ_set = '{o0, o1, o2, o3};
    endtask

    initial begin
        for (int b = 0; b < NB; b++) begin
            req_at[b] = -1; lat_cur[b] = 0; occ_cur[b] = 0; row_at[b] = 0;
        end
        set_banks(10, 10, 10, 10, 10, 10, 10, 10);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        chk(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(bank_req == '0, "R1", "bank_req after reset", bank_req, 0);

        // R6: 10-cycle banks, 15-cycle block
        phase = 2;
        pend.push_back(5);
        drain();

        // R3: request held valid across a busy window, taken when free
        phase = 3;
        pend.push_back(17);
        pend.push_back(18);
        pend.push_back(1023);
        drain();

        // R7: skewed bank latencies, latest bank decides the start
        phase = 4;
        set_banks(7, 12, 3, 9, 7, 12, 3, 9);
        pend.push_back(42);
        pend.push_back(0);
        drain();

        // R9: bank 2 stays busy well after streaming ends
        phase = 5;
        set_banks(4, 4, 4, 4, 4, 4, 20, 4);
        pend.push_back(300);
        pend.push_back(301);
        drain();

        // R8: stray data-valid while idle, then a clean fetch
        phase = 6;
        set_banks(1, 1, 1, 1, 1, 1, 1, 1);
        stray_cyc  = cyc + 3;
        stray_bank = 1;
        repeat (8) step();
        pend.push_back(77);
        drain();
        stray_cyc  = cyc + 2;
        stray_bank = 3;
        repeat (6) step();
        pend.push_back(78);
        drain();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        #2000000;
        nfail++;
        $display("FAIL watchdog: run did not complete");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule